// File: doc/BRIEF.md
# Interrupt Controller Command Sequencer

This block is the programming front end of an eight-line priority interrupt controller. Software reaches it over a byte-wide bus with one address bit. Writes to the command address either start an initialization sequence, change an operating mode, or issue an end-of-interrupt or rotation command. Writes to the data address carry the words of the initialization sequence, and load the interrupt mask once the controller is running. Reads return the request, in-service or mask register. When polling is armed, a read instead returns the current winning line and acknowledges it.

The sequencer owns the mode state: vector base, mask, rotating priority offset, auto end-of-interrupt, rotate-on-auto-EOI, fully nested and special mask flags. A separate resolver uses this state. The sequencer takes the request register, the in-service register and the resolver's winner from outside. Towards the in-service and request logic it issues one-cycle requests: an in-service clear vector, an acknowledge with its line number, and a controller clear at the start of initialization. Command pulses are combinational from the write or read strobe of the cycle that carries them. Mode state updates at the following clock edge.

Top module: `irq_cmd_seq`

## Requirements
- R1: After reset the sequencer is in normal operation. Mask, vector base and priority offset are 0. The read select points at the request register. Poll, special mask, auto end-of-interrupt, rotate-on-auto-EOI and fully nested are all off.
- R2: A command-address write with data bit 4 set pulses `ctl_clr_o` in the same cycle. At the next edge it clears mask, vector base, offset, read select, poll and every mode flag. It latches bit 0 as "fourth word needed" and bit 1 as "single controller", and enters the base-vector step.
- R3: In the base-vector step, a data-address write stores data bits 7:3 as the vector base, with bits 2:0 forced to 0.
- R4: After the base vector, the next step depends on two flags. A single controller goes to the fourth-word step if the fourth word is needed, and otherwise to normal operation. A cascaded controller first passes a cascade step whose data is ignored (the mask stays unchanged), then proceeds the same way.
- R5: In the fourth-word step, a data-address write sets fully nested mode from bit 4 and auto end-of-interrupt from bit 1, then returns to normal operation.
- R6: In normal operation, a data-address write loads the mask, which is visible on `mask_o` after the edge.
- R7: A command-address write with bit 4 = 0 and bit 3 = 1 is a mode command. Bit 2 arms poll. Bit 1 enables loading the read select from bit 0 (1 = in-service, 0 = request). Bit 6 enables loading special mask mode from bit 5.
- R8: A command-address write with bits 4:3 = 00 carries an opcode in bits 7:5. Opcode 0 clears rotate-on-auto-EOI, and opcode 4 sets it. Opcode 2 changes nothing.
- R9: Opcodes 1 and 5 clear the highest-priority set in-service bit. The search starts at line number equal to the offset and ascends mod 8. Opcode 5 also sets the offset to that line + 1 mod 8. With no in-service bit set, nothing changes.
- R10: Opcode 3 clears the in-service bit named by data bits 2:0. Opcode 7 does the same and sets the offset to that line + 1 mod 8. Opcode 6 sets the offset to bits 2:0 + 1 mod 8 and clears nothing.
- R11: A read while poll is armed returns 0x80 OR the winner's line and pulses `ack_o` with `ack_line_o`, or returns 0x00 with no acknowledge if there is no winner. Poll is then disarmed. An acknowledge while both auto end-of-interrupt and rotate-on-auto-EOI are on sets the offset to the line + 1 mod 8.
- R12: A read without poll returns the in-service or request register from the command address, according to the read select. From the data address it returns the mask.
- R13: A read and a write in the same cycle behave as follows. The read sees the state before the write, and the write is applied. A poll read together with a mode command that arms poll leaves poll armed. A same-cycle command that writes the offset overrides the offset change made by the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 1 | 0 = command address, 1 = data address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, valid while `bus_rd` is high |
| irr_in | input | 8 | Request register from the request logic |
| isr_in | input | 8 | In-service register from the in-service logic |
| win_valid | input | 1 | Resolver has a winning line |
| win_line | input | 3 | Resolver's winning line |
| mask_o | output | 8 | Interrupt mask |
| vec_base_o | output | 8 | Vector base, low three bits zero |
| prio_off_o | output | 3 | Rotating priority offset (line with highest priority) |
| auto_eoi_o | output | 1 | Auto end-of-interrupt mode |
| rot_aeoi_o | output | 1 | Rotate on auto end-of-interrupt |
| fully_nested_o | output | 1 | Special fully nested mode |
| spec_mask_o | output | 1 | Special mask mode |
| isr_clr_o | output | 8 | One-cycle in-service clear request |
| ack_o | output | 1 | One-cycle acknowledge request from a poll read |
| ack_line_o | output | 3 | Line being acknowledged, 0 when `ack_o` is low |
| ctl_clr_o | output | 1 | One-cycle controller clear at initialization start |

## Verification
Two functions can fall in the same cycle. The first is the poll read, which consumes poll, may acknowledge and may move the offset. The second is a write to either address, which may re-arm poll, load the mask or rewrite the offset. The bench raises both strobes in one cycle: a poll read together with a poll-arming mode command, a mask read together with a mask write, and an acknowledge under rotating auto end-of-interrupt together with an offset-setting command. A behavioural model judges each of these cycles on every clock. In that model the read sees the state before the write, and the write's update lands last.

// File: rtl/icsq_pkg.sv
package icsq_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_BASE   = 2'd1,
    ST_CASC   = 2'd2,
    ST_FOURTH = 2'd3
  } seq_st_t;

  typedef enum logic [2:0] {
    WK_NONE = 3'd0,
    WK_INIT = 3'd1,
    WK_MODE = 3'd2,
    WK_CMD  = 3'd3,
    WK_DATA = 3'd4
  } wr_kind_t;

  // command-address field positions (decoded by neighbours, so fixed)
  localparam int B_INIT   = 4;
  localparam int B_MODE   = 3;
  localparam int B_POLL   = 2;
  localparam int B_RSEL_E = 1;
  localparam int B_RSEL   = 0;
  localparam int B_SMM_E  = 6;
  localparam int B_SMM    = 5;
  localparam int B_NEED4  = 0;
  localparam int B_SINGLE = 1;
  localparam int B_FNM    = 4;
  localparam int B_AEOI   = 1;
  localparam int VB_LSB   = 3;
endpackage

// File: rtl/icsq_wr_class.sv
module icsq_wr_class
  import icsq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          wr,
  input  logic          addr,
  input  logic [DW-1:0] wdata,
  output wr_kind_t      kind
);
  always_comb begin
    if (!wr)                kind = WK_NONE;
    else if (addr)          kind = WK_DATA;
    else if (wdata[B_INIT]) kind = WK_INIT;
    else if (wdata[B_MODE]) kind = WK_MODE;
    else                    kind = WK_CMD;
  end
endmodule

// File: rtl/icsq_init_seq.sv
module icsq_init_seq
  import icsq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  logic    need4_in,
  input  logic    single_in,
  input  logic    step,
  output seq_st_t st_o,
  output logic    base_we_o,
  output logic    fourth_we_o
);
  seq_st_t st_q, st_d;
  logic    need4_q, need4_d, single_q, single_d;
  logic    en;

  assign en = start | step;

  always_comb begin
    st_d     = st_q;
    need4_d  = need4_q;
    single_d = single_q;
    if (start) begin
      st_d     = ST_BASE;
      need4_d  = need4_in;
      single_d = single_in;
    end else if (step) begin
      unique case (st_q)
        ST_BASE:   st_d = single_q ? (need4_q ? ST_FOURTH : ST_RUN) : ST_CASC;
        ST_CASC:   st_d = need4_q ? ST_FOURTH : ST_RUN;
        ST_FOURTH: st_d = ST_RUN;
        default:   st_d = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_RUN;
      need4_q  <= 1'b0;
      single_q <= 1'b0;
    end else if (en) begin
      st_q     <= st_d;
      need4_q  <= need4_d;
      single_q <= single_d;
    end
  end

  assign st_o        = st_q;
  assign base_we_o   = step & ~start & (st_q == ST_BASE);
  assign fourth_we_o = step & ~start & (st_q == ST_FOURTH);
endmodule

// File: rtl/icsq_rot_find.sv
module icsq_rot_find #(
  parameter  int LINES = 8,
  localparam int LW    = $clog2(LINES)
) (
  input  logic [LINES-1:0] req,
  input  logic [LW-1:0]    base,
  output logic             hit,
  output logic [LW-1:0]    line
);
  // LINES must be a power of two so that the index wraps in LW bits
  always_comb begin
    hit  = 1'b0;
    line = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (req[LW'(int'(base) + i)]) begin
        hit  = 1'b1;
        line = LW'(int'(base) + i);
      end
    end
  end
endmodule

// File: rtl/irq_cmd_seq.sv
module irq_cmd_seq
  import icsq_pkg::*;
#(
  parameter  int LINES = 8,
  parameter  int DW    = 8,
  localparam int LW    = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  input  logic             bus_wr,
  input  logic             bus_rd,
  output logic [DW-1:0]    bus_rdata,
  input  logic [LINES-1:0] irr_in,
  input  logic [LINES-1:0] isr_in,
  input  logic             win_valid,
  input  logic [LW-1:0]    win_line,
  output logic [LINES-1:0] mask_o,
  output logic [DW-1:0]    vec_base_o,
  output logic [LW-1:0]    prio_off_o,
  output logic             auto_eoi_o,
  output logic             rot_aeoi_o,
  output logic             fully_nested_o,
  output logic             spec_mask_o,
  output logic [LINES-1:0] isr_clr_o,
  output logic             ack_o,
  output logic [LW-1:0]    ack_line_o,
  output logic             ctl_clr_o
);
  wr_kind_t kind;
  seq_st_t  seq_st;
  logic     base_we, fourth_we, run_w;
  logic     init_go, data_go, mode_go, cmd_go, mask_we;
  logic     nsp_hit;
  logic [LW-1:0] nsp_line, lnum;
  logic [2:0]    opc;
  logic     poll_rd, ack_w, rearm;

  logic [LINES-1:0] mask_q, mask_d;
  logic [DW-1:0]    vec_q, vec_d;
  logic [LW-1:0]    off_q, off_d;
  logic aeoi_q, aeoi_d, rot_q, rot_d, fnm_q, fnm_d;
  logic smm_q, smm_d, rsel_q, rsel_d, poll_q, poll_d;
  logic reg_en;

  icsq_wr_class #(.DW(DW)) u_class (
    .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata), .kind(kind)
  );

  assign init_go = (kind == WK_INIT);
  assign data_go = (kind == WK_DATA);
  assign mode_go = (kind == WK_MODE);
  assign cmd_go  = (kind == WK_CMD);

  icsq_init_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(init_go),
    .need4_in(bus_wdata[B_NEED4]), .single_in(bus_wdata[B_SINGLE]),
    .step(data_go), .st_o(seq_st), .base_we_o(base_we), .fourth_we_o(fourth_we)
  );

  assign run_w   = (seq_st == ST_RUN);
  assign mask_we = data_go & run_w;

  icsq_rot_find #(.LINES(LINES)) u_find (
    .req(isr_in), .base(off_q), .hit(nsp_hit), .line(nsp_line)
  );

  assign opc     = bus_wdata[DW-1 -: 3];
  assign lnum    = bus_wdata[LW-1:0];
  assign poll_rd = bus_rd & poll_q;
  assign ack_w   = poll_rd & win_valid;
  assign rearm   = mode_go & bus_wdata[B_POLL];

  // command pulses
  always_comb begin
    isr_clr_o = '0;
    if (cmd_go) begin
      if ((opc == 3'd1 || opc == 3'd5) && nsp_hit) isr_clr_o[nsp_line] = 1'b1;
      if (opc == 3'd3 || opc == 3'd7)              isr_clr_o[lnum]     = 1'b1;
    end
  end
  assign ack_o      = ack_w;
  assign ack_line_o = ack_w ? win_line : '0;
  assign ctl_clr_o  = init_go;

  // read path: state before any same-cycle write
  always_comb begin
    if (poll_q)        bus_rdata = win_valid ? (DW'(1) << (DW-1)) | DW'(win_line) : '0;
    else if (bus_addr) bus_rdata = DW'(mask_q);
    else               bus_rdata = rsel_q ? DW'(isr_in) : DW'(irr_in);
  end

  // next state: acknowledge first, write last
  always_comb begin
    mask_d = mask_q; vec_d = vec_q; off_d = off_q;
    aeoi_d = aeoi_q; rot_d = rot_q; fnm_d = fnm_q;
    smm_d  = smm_q;  rsel_d = rsel_q; poll_d = poll_q;
    if (poll_rd) poll_d = 1'b0;
    if (ack_w && aeoi_q && rot_q) off_d = win_line + LW'(1);
    if (init_go) begin
      mask_d = '0; vec_d = '0; off_d = '0;
      aeoi_d = 1'b0; rot_d = 1'b0; fnm_d = 1'b0;
      smm_d  = 1'b0; rsel_d = 1'b0; poll_d = 1'b0;
    end else begin
      if (mask_we)   mask_d = bus_wdata[LINES-1:0];
      if (base_we)   vec_d  = {bus_wdata[DW-1:VB_LSB], VB_LSB'(0)};
      if (fourth_we) begin
        fnm_d  = bus_wdata[B_FNM];
        aeoi_d = bus_wdata[B_AEOI];
      end
      if (mode_go) begin
        if (rearm)                poll_d = 1'b1;
        if (bus_wdata[B_RSEL_E])  rsel_d = bus_wdata[B_RSEL];
        if (bus_wdata[B_SMM_E])   smm_d  = bus_wdata[B_SMM];
      end
      if (cmd_go) begin
        unique case (opc)
          3'd0, 3'd4: rot_d = opc[2];
          3'd5:       if (nsp_hit) off_d = nsp_line + LW'(1);
          3'd6, 3'd7: off_d = lnum + LW'(1);
          default:    ;
        endcase
      end
    end
  end

  assign reg_en = bus_wr | bus_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0; vec_q <= '0; off_q <= '0;
      aeoi_q <= 1'b0; rot_q <= 1'b0; fnm_q <= 1'b0;
      smm_q  <= 1'b0; rsel_q <= 1'b0; poll_q <= 1'b0;
    end else if (reg_en) begin
      mask_q <= mask_d; vec_q <= vec_d; off_q <= off_d;
      aeoi_q <= aeoi_d; rot_q <= rot_d; fnm_q <= fnm_d;
      smm_q  <= smm_d;  rsel_q <= rsel_d; poll_q <= poll_d;
    end
  end

  assign mask_o         = mask_q;
  assign vec_base_o     = vec_q;
  assign prio_off_o     = off_q;
  assign auto_eoi_o     = aeoi_q;
  assign rot_aeoi_o     = rot_q;
  assign fully_nested_o = fnm_q;
  assign spec_mask_o    = smm_q;
endmodule

// File: rtl/icsq_chk.sv
module icsq_chk
  import icsq_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       bus_addr,
  input logic [7:0] bus_wdata,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [7:0] bus_rdata,
  input logic [7:0] mask_o,
  input logic [7:0] vec_base_o,
  input logic [2:0] prio_off_o,
  input logic [7:0] isr_clr_o,
  input logic       ack_o,
  input logic       ctl_clr_o,
  input seq_st_t    seq_st,
  input logic       poll_q
);
  // R2
  init_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_clr_o |=> (mask_o == 8'h00 && prio_off_o == 3'd0 && vec_base_o == 8'h00));

  // R3
  base_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr && seq_st == ST_BASE) |=> vec_base_o == {$past(bus_wdata[7:3]), 3'b000});

  // R6
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr && seq_st == ST_RUN) |=> mask_o == $past(bus_wdata));

  // R10
  single_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(isr_clr_o));

  // R11
  ack_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> (bus_rd && bus_rdata[7]));

  // R11
  poll_oneshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && poll_q && !(bus_wr && !bus_addr && bus_wdata[4:2] == 3'b011)) |=> !poll_q);

  // R13
  read_before_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_wr && bus_addr && !poll_q) |-> bus_rdata == mask_o);
endmodule

bind irq_cmd_seq icsq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .mask_o(mask_o),
  .vec_base_o(vec_base_o), .prio_off_o(prio_off_o), .isr_clr_o(isr_clr_o),
  .ack_o(ack_o), .ctl_clr_o(ctl_clr_o), .seq_st(seq_st), .poll_q(poll_q)
);

// File: tb/irq_cmd_seq_bench.sv
module irq_cmd_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       a_i, w_i, r_i, wv_i;
  logic [7:0] d_i, irr_i, isr_i;
  logic [2:0] wl_i;
  logic [7:0] rdata, mask, vbase, clr;
  logic [2:0] off, ackl;
  logic       aeoi, rot, fnm, smm, ack, ctl;

  int nchk = 0;
  int nerr = 0;

  // behavioural model state
  int m_st, m_n4, m_sg, m_mask, m_vec, m_off, m_aeoi, m_rot, m_fnm, m_smm, m_rsel, m_poll;

  always #5 clk = ~clk;

  irq_cmd_seq u_irq_cmd_seq (
    .clk(clk), .rst_n(rst_n), .bus_addr(a_i), .bus_wdata(d_i), .bus_wr(w_i),
    .bus_rd(r_i), .bus_rdata(rdata), .irr_in(irr_i), .isr_in(isr_i),
    .win_valid(wv_i), .win_line(wl_i), .mask_o(mask), .vec_base_o(vbase),
    .prio_off_o(off), .auto_eoi_o(aeoi), .rot_aeoi_o(rot), .fully_nested_o(fnm),
    .spec_mask_o(smm), .isr_clr_o(clr), .ack_o(ack), .ack_line_o(ackl), .ctl_clr_o(ctl)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int find_isr(input int v, input int o);
    for (int k = 0; k < 8; k++) begin
      int ln;
      ln = (o + k) % 8;
      if (((v >> ln) & 1) == 1) return ln;
    end
    return -1;
  endfunction

  function automatic void model_reset();
    m_st = 0; m_n4 = 0; m_sg = 0; m_mask = 0; m_vec = 0; m_off = 0;
    m_aeoi = 0; m_rot = 0; m_fnm = 0; m_smm = 0; m_rsel = 0; m_poll = 0;
  endfunction

  // one bus cycle: drive at negedge, compare, clock, update model
  task automatic cyc(input int a, input int d, input int w, input int r);
    int e_rd, e_clr, e_ack, e_ackl, opc, f;
    string rtag;
    a_i = a[0]; d_i = 8'(d); w_i = w[0]; r_i = r[0];
    #1;
    // registered outputs
    chk("R6/R4", "mask", int'(mask), m_mask);
    chk("R3", "vec_base", int'(vbase), m_vec);
    chk("R9", "offset", int'(off), m_off);
    chk("R5", "auto_eoi", int'(aeoi), m_aeoi);
    chk("R5", "fully_nested", int'(fnm), m_fnm);
    chk("R8", "rot_aeoi", int'(rot), m_rot);
    chk("R7", "spec_mask", int'(smm), m_smm);
    // combinational outputs
    opc = (d >> 5) & 7;
    f = find_isr(int'(isr_i), m_off);
    e_clr = 0;
    if (w == 1 && a == 0 && (d & 8'h18) == 0) begin
      if ((opc == 1 || opc == 5) && f >= 0) e_clr = 1 << f;
      if (opc == 3 || opc == 7) e_clr = 1 << (d & 7);
    end
    chk("R9/R10", "isr_clr", int'(clr), e_clr);
    e_ack  = (r == 1 && m_poll == 1 && wv_i) ? 1 : 0;
    e_ackl = e_ack ? int'(wl_i) : 0;
    chk("R11", "ack", int'(ack), e_ack);
    chk("R11", "ack_line", int'(ackl), e_ackl);
    chk("R2", "ctl_clr", int'(ctl), (w == 1 && a == 0 && (d & 8'h10) != 0) ? 1 : 0);
    if (r == 1) begin
      if (m_poll == 1)  e_rd = wv_i ? (8'h80 | int'(wl_i)) : 0;
      else if (a == 1)  e_rd = m_mask;
      else              e_rd = (m_rsel == 1) ? int'(isr_i) : int'(irr_i);
      rtag = (w == 1) ? "R13" : ((m_poll == 1) ? "R11" : "R12");
      chk(rtag, "rdata", int'(rdata), e_rd);
    end
    @(posedge clk);
    // model update: read effects, then the write
    if (r == 1 && m_poll == 1) begin
      if (wv_i && m_aeoi == 1 && m_rot == 1) m_off = (int'(wl_i) + 1) % 8;
      m_poll = 0;
    end
    if (w == 1) begin
      if (a == 0) begin
        if ((d & 8'h10) != 0) begin
          model_reset();
          m_st = 1; m_n4 = d & 1; m_sg = (d >> 1) & 1;
        end else if ((d & 8'h08) != 0) begin
          if ((d & 4) != 0) m_poll = 1;
          if ((d & 2) != 0) m_rsel = d & 1;
          if ((d & 8'h40) != 0) m_smm = (d >> 5) & 1;
        end else begin
          case (opc)
            0, 4: m_rot = opc >> 2;
            5: if (f >= 0) m_off = (f + 1) % 8;
            6, 7: m_off = ((d & 7) + 1) % 8;
            default: ;
          endcase
        end
      end else begin
        case (m_st)
          0: m_mask = d & 8'hFF;
          1: begin m_vec = d & 8'hF8; m_st = (m_sg == 1) ? ((m_n4 == 1) ? 3 : 0) : 2; end
          2: m_st = (m_n4 == 1) ? 3 : 0;
          default: begin m_fnm = (d >> 4) & 1; m_aeoi = (d >> 1) & 1; m_st = 0; end
        endcase
      end
    end
    @(negedge clk);
    a_i = 1'b0; w_i = 1'b0; r_i = 1'b0; d_i = 8'h00;
  endtask

  task automatic wr0(input int d); cyc(0, d, 1, 0); endtask
  task automatic wr1(input int d); cyc(1, d, 1, 0); endtask
  task automatic rd0(); cyc(0, 0, 0, 1); endtask
  task automatic rd1(); cyc(1, 0, 0, 1); endtask

  initial begin
    #(200000 * 10);
    nerr++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    rst_n = 1'b0; a_i = 0; w_i = 0; r_i = 0; d_i = 0;
    irr_i = 0; isr_i = 0; wv_i = 0; wl_i = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "mask", int'(mask), 0);
    chk("R1", "vec_base", int'(vbase), 0);
    chk("R1", "offset", int'(off), 0);
    chk("R1", "modes", int'({aeoi, rot, fnm, smm}), 0);
    irr_i = 8'h3C; isr_i = 8'h81;
    rd0();                       // R1 read select on request register
    rd1();
    // R2 R3 R5: single controller with fourth word
    wr0(8'h13); wr1(8'h47); wr1(8'h12);
    wr1(8'hA5); rd1(); rd0();    // R6 R12
    wr0(8'h0B); rd0();           // R7 read select in-service
    wr0(8'h0A); rd0();
    wr0(8'h68); wr0(8'h48);      // R7 special mask on, off
    wr0(8'h28);                  // R7 bit6 clear: special mask unchanged
    // R4 cascaded without fourth word: cascade data must not reach mask
    wr0(8'h10); wr1(8'h27); wr1(8'hFF); wr1(8'h3C); rd1();
    // R4 cascaded with fourth word
    wr0(8'h11); wr1(8'h08); wr1(8'h55); wr1(8'h10); wr1(8'h99);
    // R4 single without fourth word
    wr0(8'h12); wr1(8'hF9); wr1(8'h0F);
    // R9 R10 opcodes
    isr_i = 8'h90;
    wr0(8'h20);                  // nonspecific, offset 0 -> line 4
    wr0(8'hC5);                  // offset 6
    wr0(8'hA0);                  // nonspecific+rotate -> line 7, offset 0
    wr0(8'h62);                  // specific line 2
    wr0(8'hE3);                  // specific+rotate line 3, offset 4
    wr0(8'h20);                  // from 4: line 4
    isr_i = 8'h00;
    wr0(8'h20); wr0(8'hA0);      // nothing set: no change
    wr0(8'h80); wr0(8'h40); wr0(8'h00);  // R8 rotate on, no-op, off
    // R11 poll
    wv_i = 1; wl_i = 3'd5;
    wr0(8'h0C); rd0(); rd0();
    wv_i = 0;
    wr0(8'h0C); rd1();
    // R11 rotation on acknowledge under auto end-of-interrupt
    wr0(8'h13); wr1(8'h00); wr1(8'h02); wr0(8'h80);
    wv_i = 1; wl_i = 3'd3;
    wr0(8'h0C); rd0();
    wl_i = 3'd7;
    wr0(8'h0C); rd1();
    // R13 same-cycle read and write
    wr0(8'h0C);
    cyc(0, 8'h0C, 1, 1);         // poll read with re-arm
    rd0();                       // still armed
    wr1(8'h11);
    cyc(1, 8'h66, 1, 1);         // mask read returns old mask
    rd1();
    wl_i = 3'd1;
    wr0(8'h0C);
    cyc(0, 8'hC2, 1, 1);         // ack rotation overridden by offset command
    wl_i = 3'd6;
    wr0(8'h0C);
    cyc(0, 8'h13, 1, 1);         // poll read during initialization start
    repeat (2) rd0();
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule